// File: doc/BRIEF.md
# Power-Down Clock Output Gate

This block sits between a clock synthesizer's dividers and its output pins. It parks a bank of generated clocks when an asynchronous, active-low power-down request arrives, and brings them back without glitches when the request is released. All generated clocks enter as levels. A fast sampling clock `clk` oversamples them, and every gated output is a registered copy of its input level. Single-ended clocks park low. Differential pairs park with the true leg high. Per pair, the complement leg is either floated on its own or floated together with the true leg.

The request passes through a two-flop synchronizer. It is then qualified on rising edges of the complement leg of one reference pair (pair `QUAL_PAIR`, the CPU pair). Once every output has reached its parked state, a core-stop indication is raised. That indication is what the oscillator and loop shutdown logic, which lies outside this block, acts on. On release, each output waits for its own rising edge and resumes there, so the first pulse it emits is a full high phase.

Top module: `pd_clock_gate`

## Requirements
- R1: The request is synchronized by two flops. It takes effect only after the synchronized request has been low at two consecutive rising edges of the reference pair's complement input. Before that, every output follows its input and both output-enables of every pair stay 1.
- R2: After qualification, each single-ended output follows its input until that input's next falling edge (1 then 0). From that edge on, the output is held at 0.
- R3: After qualification, each differential pair follows its inputs until its complement input's next falling edge. From that edge on, the true output is 1 and the complement output is 0.
- R4: A parked pair whose drive-mode bit `pair_float` is 0 keeps `pair_t_oe`=1 and sets `pair_c_oe`=0.
- R5: A parked pair whose drive-mode bit is 1 sets both `pair_t_oe` and `pair_c_oe` to 0.
- R6: `core_stop` is 1 only while the request is still qualified and every output is parked. It rises one sample after the last output parks and falls one sample after the synchronized request is seen high.
- R7: After release, a parked single-ended output stays 0 until the first rising edge of its input. It resumes with a 1 at that edge.
- R8: After release, a fully floated pair drives its true leg (`pair_t_oe`=1, true output 1) one sample after the synchronized release is taken, before that pair resumes.
- R9: If the synchronized request returns high before the second qualifying edge, the count is cleared and nothing parks.
- R10: After release, a parked pair resumes at the first rising edge of its true input. The complement output-enable returns to 1 there, and the outputs follow the inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| se_clk_in | input | N_SE | Single-ended generated clock levels |
| pair_t_in | input | N_PAIR | True legs of the differential pairs |
| pair_c_in | input | N_PAIR | Complement legs of the differential pairs |
| pair_float | input | N_PAIR | Drive mode per pair: 0 true driven high, 1 both legs floated |
| se_clk_out | output | N_SE | Gated single-ended clocks |
| pair_t_out | output | N_PAIR | Gated true legs |
| pair_c_out | output | N_PAIR | Gated complement legs |
| pair_t_oe | output | N_PAIR | True-leg output enable |
| pair_c_oe | output | N_PAIR | Complement-leg output enable |
| core_stop | output | 1 | All outputs parked; core may be stopped |

## Verification
The hardest state to reach is the window in which the request has been released but the outputs are still parked. In that window `core_stop` has already fallen and a floated pair has re-driven its true leg, while no output has yet seen its own resume edge. The stimulus reaches it by releasing the request at a moment when the synchronizer delay lands the release between the single-ended falling edge and the next rising edge. It also chooses a clock phase in which the reference complement leg falls before the single-ended clocks do. This makes the pairs park two samples earlier than the single-ended outputs, so the window in which only some outputs are parked is exposed.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [0:0] {
        GS_RUN  = 1'b0,
        GS_PARK = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic t;
        logic c;
        logic t_oe;
        logic c_oe;
    } leg_drive_t;

    localparam leg_drive_t LEG_RESET = '{t: 1'b0, c: 1'b0, t_oe: 1'b1, c_oe: 1'b1};

    function automatic logic edge_up(input logic prev, input logic cur);
        return cur & ~prev;
    endfunction

    function automatic logic edge_down(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/pdg_qualify.sv
module pdg_qualify
    import pdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_n_i,
    input  logic ref_c_i,
    output logic stop_o
);
    localparam int EDGES_NEEDED = 2;
    localparam int CW = $clog2(EDGES_NEEDED + 1);

    logic          req_s1, req_s2;
    logic          ref_prev;
    logic [CW-1:0] edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_s1   <= 1'b1;
            req_s2   <= 1'b1;
            ref_prev <= 1'b0;
            edge_cnt <= '0;
            stop_o   <= 1'b0;
        end else begin
            req_s1   <= req_n_i;
            req_s2   <= req_s1;
            ref_prev <= ref_c_i;
            if (req_s2) begin
                edge_cnt <= '0;
                stop_o   <= 1'b0;
            end else if (!stop_o && edge_up(ref_prev, ref_c_i)) begin
                if (edge_cnt == CW'(EDGES_NEEDED - 1)) begin
                    stop_o <= 1'b1;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end

    // R1: a stop only begins from a request seen low through the synchronizer
    a_r1_qualified_low: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_o) |-> $past(!req_s2));

    // R9: a synchronized high request always clears the stop
    a_r9_release_clears: assert property (@(posedge clk) disable iff (rst)
        req_s2 |=> !stop_o);

endmodule

// File: rtl/pdg_se_gate.sv
module pdg_se_gate
    import pdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_i,
    input  logic clk_i,
    output logic clk_o,
    output logic parked_o
);
    gate_state_e state;
    logic        prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_RUN;
            prev  <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            prev <= clk_i;
            case (state)
                GS_RUN: begin
                    if (stop_i && edge_down(prev, clk_i)) begin
                        state <= GS_PARK;
                        clk_o <= 1'b0;
                    end else begin
                        clk_o <= clk_i;
                    end
                end
                default: begin
                    if (!stop_i && edge_up(prev, clk_i)) begin
                        state <= GS_RUN;
                        clk_o <= 1'b1;
                    end else begin
                        clk_o <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign parked_o = (state == GS_PARK);

    // R2: a parked single-ended output is low
    a_r2_parked_low: assert property (@(posedge clk) disable iff (rst)
        parked_o |-> !clk_o);

    // R7: leaving park always starts with a high phase
    a_r7_resume_high: assert property (@(posedge clk) disable iff (rst)
        $fell(parked_o) |-> clk_o);

endmodule

// File: rtl/pdg_pair_gate.sv
module pdg_pair_gate
    import pdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_i,
    input  logic       float_i,
    input  logic       t_i,
    input  logic       c_i,
    output leg_drive_t drv_o,
    output logic       parked_o
);
    gate_state_e state;
    logic        prev_t, prev_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= GS_RUN;
            prev_t <= 1'b0;
            prev_c <= 1'b0;
            drv_o  <= LEG_RESET;
        end else begin
            prev_t <= t_i;
            prev_c <= c_i;
            case (state)
                GS_RUN: begin
                    if (stop_i && edge_down(prev_c, c_i)) begin
                        state <= GS_PARK;
                        drv_o <= '{t: 1'b1, c: 1'b0, t_oe: ~float_i, c_oe: 1'b0};
                    end else begin
                        drv_o <= '{t: t_i, c: c_i, t_oe: 1'b1, c_oe: 1'b1};
                    end
                end
                default: begin
                    if (!stop_i && edge_up(prev_t, t_i)) begin
                        state <= GS_RUN;
                        drv_o <= '{t: 1'b1, c: c_i, t_oe: 1'b1, c_oe: 1'b1};
                    end else begin
                        drv_o.t    <= 1'b1;
                        drv_o.c    <= 1'b0;
                        drv_o.c_oe <= 1'b0;
                        if (!stop_i) begin
                            drv_o.t_oe <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign parked_o = (state == GS_PARK);

    // R3: a parked pair holds its true leg high and complement low
    a_r3_true_high: assert property (@(posedge clk) disable iff (rst)
        parked_o |-> (drv_o.t && !drv_o.c));

    // R4: the complement leg is never driven while parked
    a_r4_comp_float: assert property (@(posedge clk) disable iff (rst)
        parked_o |-> !drv_o.c_oe);

    // R8: one sample after release is seen, the true leg is driven
    a_r8_redrive: assert property (@(posedge clk) disable iff (rst)
        (parked_o && !stop_i) |=> drv_o.t_oe);

    // R10: resuming re-enables the complement leg
    a_r10_resume_enable: assert property (@(posedge clk) disable iff (rst)
        $fell(parked_o) |-> (drv_o.c_oe && drv_o.t_oe));

endmodule

// File: rtl/pd_clock_gate.sv
module pd_clock_gate
    import pdg_pkg::*;
#(
    parameter int N_SE      = 9,
    parameter int N_PAIR    = 4,
    parameter int QUAL_PAIR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_req_n,
    input  logic [N_SE-1:0]   se_clk_in,
    input  logic [N_PAIR-1:0] pair_t_in,
    input  logic [N_PAIR-1:0] pair_c_in,
    input  logic [N_PAIR-1:0] pair_float,
    output logic [N_SE-1:0]   se_clk_out,
    output logic [N_PAIR-1:0] pair_t_out,
    output logic [N_PAIR-1:0] pair_c_out,
    output logic [N_PAIR-1:0] pair_t_oe,
    output logic [N_PAIR-1:0] pair_c_oe,
    output logic              core_stop
);
    localparam int N_ALL = N_SE + N_PAIR;

    logic             stop;
    logic [N_ALL-1:0] parked;

    pdg_qualify u_qual (
        .clk     (clk),
        .rst     (rst),
        .req_n_i (pd_req_n),
        .ref_c_i (pair_c_in[QUAL_PAIR]),
        .stop_o  (stop)
    );

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        pdg_se_gate u_se (
            .clk      (clk),
            .rst      (rst),
            .stop_i   (stop),
            .clk_i    (se_clk_in[i]),
            .clk_o    (se_clk_out[i]),
            .parked_o (parked[i])
        );
    end

    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
        leg_drive_t drv;
        pdg_pair_gate u_pair (
            .clk      (clk),
            .rst      (rst),
            .stop_i   (stop),
            .float_i  (pair_float[j]),
            .t_i      (pair_t_in[j]),
            .c_i      (pair_c_in[j]),
            .drv_o    (drv),
            .parked_o (parked[N_SE+j])
        );
        assign pair_t_out[j] = drv.t;
        assign pair_c_out[j] = drv.c;
        assign pair_t_oe[j]  = drv.t_oe;
        assign pair_c_oe[j]  = drv.c_oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_stop <= 1'b0;
        end else begin
            core_stop <= stop && (&parked);
        end
    end

    // R6: the core is told to stop only once everything has been parked
    a_r6_core_after_park: assert property (@(posedge clk) disable iff (rst)
        core_stop |-> $past(&parked));

    // R5: a floated pair that is parked during a stop drives neither leg
    a_r5_float_both: assert property (@(posedge clk) disable iff (rst)
        (core_stop && stop) |-> ((pair_t_oe & pair_float) == '0));

endmodule

// File: tb/pd_clock_gate_bench.sv
module pd_clock_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int NP = 2;
    localparam int NSTEP = 36;
    localparam int NSEG = 10;

    // Segment rows: first step, last step, request level, expected class
    // class 0 follow, 1 pairs parked, 2 all parked, 3 all parked + core, 4 released still parked
    localparam int SEG [NSEG][4] = '{
        '{0, 3, 1, 0}, '{4, 11, 0, 0}, '{12, 13, 0, 1}, '{14, 14, 0, 2},
        '{15, 15, 0, 3}, '{16, 18, 1, 3}, '{19, 19, 1, 4}, '{20, 23, 1, 0},
        '{24, 26, 0, 0}, '{27, 35, 1, 0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pd_req_n = 1'b1;
    logic [NS-1:0] se_in = '0;
    logic [NP-1:0] t_in = '0, c_in = '0;
    logic [NP-1:0] flt = 2'b10;
    logic [NS-1:0] se_out;
    logic [NP-1:0] t_out, c_out, t_oe, c_oe;
    logic          core;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_clock_gate #(.N_SE(NS), .N_PAIR(NP), .QUAL_PAIR(0)) u_pd_clock_gate (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n),
        .se_clk_in(se_in), .pair_t_in(t_in), .pair_c_in(c_in), .pair_float(flt),
        .se_clk_out(se_out), .pair_t_out(t_out), .pair_c_out(c_out),
        .pair_t_oe(t_oe), .pair_c_oe(c_oe), .core_stop(core)
    );

    task automatic check(input string tag, input string what, input int step,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s step %0d: got %0h expected %0h", tag, what, step, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: outputs low, enables high, core_stop low (R6)
        check("R6", "core reset", -1, {7'd0, core}, 8'd0);
        check("R2", "se reset", -1, {6'd0, se_out}, 8'd0);
        check("R4", "oe reset", -1, {4'd0, t_oe, c_oe}, 8'h0f);
        check("R3", "legs reset", -1, {4'd0, t_out, c_out}, 8'd0);
        rst = 1'b0;

        for (int i = 0; i < NSTEP; i++) begin
            int cls;
            logic hi;
            logic [NS-1:0] e_se;
            logic [NP-1:0] e_t, e_c, e_toe, e_coe;
            logic e_core;
            string tag;
            cls = 0;
            for (int s = 0; s < NSEG; s++) begin
                if (i >= SEG[s][0] && i <= SEG[s][1]) begin
                    cls = SEG[s][3];
                    pd_req_n = SEG[s][2][0];
                end
            end
            hi = ((i % 4) < 2);
            se_in = {NS{hi}};
            t_in = {NP{hi}};
            c_in = {NP{~hi}};
            @(posedge clk);
            @(negedge clk);
            case (cls)
                0: begin e_se = se_in; e_t = t_in; e_c = c_in; e_toe = '1; e_coe = '1;
                         e_core = 1'b0; tag = (i < 12) ? "R1" : ((i < 24) ? "R10" : "R9"); end
                1: begin e_se = se_in; e_t = '1; e_c = '0; e_toe = ~flt; e_coe = '0;
                         e_core = 1'b0; tag = "R3"; end
                2: begin e_se = '0; e_t = '1; e_c = '0; e_toe = ~flt; e_coe = '0;
                         e_core = 1'b0; tag = "R2"; end
                3: begin e_se = '0; e_t = '1; e_c = '0; e_toe = ~flt; e_coe = '0;
                         e_core = 1'b1; tag = "R6"; end
                default: begin e_se = '0; e_t = '1; e_c = '0; e_toe = '1; e_coe = '0;
                         e_core = 1'b0; tag = "R8"; end
            endcase
            check(tag, "se_out", i, {6'd0, se_out}, {6'd0, e_se});
            check(tag, "pair legs", i, {4'd0, t_out, c_out}, {4'd0, e_t, e_c});
            check(cls == 4 ? "R8" : (cls == 0 ? tag : "R5"), "t_oe", i, {6'd0, t_oe}, {6'd0, e_toe});
            check(cls == 0 ? tag : "R4", "c_oe", i, {6'd0, c_oe}, {6'd0, e_coe});
            check(cls == 0 ? tag : "R6", "core_stop", i, {7'd0, core}, {7'd0, e_core});
            if (i == 20) begin
                // R7: single-ended output resumes with a full high phase
                check("R7", "se resume", i, {6'd0, se_out}, 8'h03);
            end
        end
        finish_run();
    end
endmodule